// File: doc/BRIEF.md
# SPI Transmit Byte Queue

This block sits between a register bus and a serial shifter and holds the bytes waiting to be sent. Software fills it through either of two push ports. The narrow port enqueues one byte. The wide port enqueues a packed 32-bit word as four bytes, least significant byte first. The shifter drains the queue one byte at a time through a first-word-fall-through pop port.

Occupancy is reported as a count of free bytes. Three interrupt sources are provided:
- an empty level;
- a full level;
- a one-cycle overrun pulse, raised whenever data offered on a push port is refused.

A push that does not fit is discarded as a whole. A word push that finds fewer than four free bytes stores none of its bytes.

Top module: `spi_tx_byte_queue`

## Requirements
- R1: After reset the queue is empty: `irq_empty` is 1, `irq_full` is 0, `irq_overrun` is 0, `pop_valid` is 0 and `free_bytes` equals DEPTH (64).
- R2: A byte push with at least one free byte and no word push in the same cycle enqueues `byte_data[7:0]` at the tail.
- R3: A word push with at least four free bytes enqueues four bytes in this order: `word_data[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`.
- R4: `free_bytes` equals DEPTH minus the number of stored bytes, and it reflects each accepted push and pop from the cycle after the clock edge that performed it.
- R5: `irq_empty` is 1 exactly when no byte is stored. `irq_full` is 1 exactly when DEPTH bytes are stored.
- R6: A word push seen with fewer than four free bytes stores none of its bytes and raises `irq_overrun` for the following cycle.
- R7: A byte push seen with zero free bytes is dropped and raises `irq_overrun` for the following cycle.
- R8: A byte push and a word push in the same cycle is a collision. The byte is dropped and `irq_overrun` is raised for the following cycle. The word is handled as under R3 or R6.
- R9: While `pop_valid` is 1, `pop_data` shows the oldest stored byte. `pop_req` removes that byte at the clock edge. `pop_req` on an empty queue has no effect.
- R10: A pop and a push in the same cycle both take effect. Push admission uses the free count from before that cycle's pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_push | input | 1 | Push one byte |
| byte_data | input | 8 | Byte to push |
| word_push | input | 1 | Push four packed bytes |
| word_data | input | 32 | Packed word to push, low byte first |
| pop_req | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte |
| pop_valid | output | 1 | Queue holds at least one byte |
| free_bytes | output | 16 | Number of free byte slots |
| irq_empty | output | 1 | Queue empty level |
| irq_full | output | 1 | Queue full level |
| irq_overrun | output | 1 | One-cycle pulse after a refused push |

## Verification
Every result of a push or pop is due one cycle after the rising edge that sampled the request. This covers the free count, the empty and full levels, the new head byte and the overrun pulse. The bench drives inputs just after a falling edge and lets one rising edge act on them. At the next falling edge it compares every output with a queue-based reference model that was advanced on that same rising edge. Directed phases cover the word refusal at three free bytes, a byte offered when full, collisions with and without room, and a pop on an empty queue. A pop together with a push on a full queue is also covered. A long random phase follows.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
   localparam int BYTE_W = 8;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
   parameter int DEPTH = 64,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = spi_txq_pkg::bits_for(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_push,
   input  logic             word_push,
   input  logic             pop_req,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    rd_ptr,
   output logic [CW-1:0]    count,
   output logic [LANES-1:0] lane_we,
   output logic             ovr_q
);
   logic [CW-1:0] free_n;
   logic          word_ok, byte_ok, pop_fire, ovr_d;
   logic [CW-1:0] n_push;

   assign free_n   = CW'(DEPTH) - count;
   assign word_ok  = word_push && (free_n >= CW'(LANES));
   assign byte_ok  = byte_push && !word_push && (free_n != '0);
   assign pop_fire = pop_req && (count != '0);
   assign ovr_d    = (word_push && !word_ok) || (byte_push && !byte_ok);
   assign n_push   = word_ok ? CW'(LANES) : (byte_ok ? CW'(1) : '0);

   for (genvar k = 0; k < LANES; k++) begin : g_lane_we
      if (k == 0) begin : g_first
         assign lane_we[k] = word_ok || byte_ok;
      end else begin : g_rest
         assign lane_we[k] = word_ok;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         wr_ptr <= wr_ptr + AW'(n_push);
         if (pop_fire) rd_ptr <= rd_ptr + AW'(1);
         count  <= count + n_push - CW'(pop_fire);
         ovr_q  <= ovr_d;
      end
   end

   assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_word_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (word_push && free_n >= CW'(LANES) && !pop_req) |=> count == $past(count) + CW'(LANES));
   assert_word_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_push && free_n < CW'(LANES) && !pop_req) |=> ($stable(count) && ovr_q));
   assert_byte_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_push && count == CW'(DEPTH)) |=> ovr_q);
   assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_push && word_push) |=> ovr_q);
   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && count == '0) |=> $stable(rd_ptr));
endmodule

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DEPTH = 64,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic [AW-1:0]       wr_ptr,
   input  logic [LANES-1:0]    lane_we,
   input  logic [LANES*8-1:0]  lane_data,
   input  logic [AW-1:0]       rd_ptr,
   output logic [7:0]          rd_data
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] lane_addr [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_addr
      assign lane_addr[k] = wr_ptr + AW'(k);
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (lane_we[k]) mem[lane_addr[k]] <= lane_data[k*8 +: 8];
      end
   end

   assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/spi_tx_byte_queue.sv
module spi_tx_byte_queue #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 32,
   parameter int FREE_W = 16,
   localparam int LANES = WORD_W / 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = spi_txq_pkg::bits_for(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_push,
   input  logic [7:0]        byte_data,
   input  logic              word_push,
   input  logic [WORD_W-1:0] word_data,
   input  logic              pop_req,
   output logic [7:0]        pop_data,
   output logic              pop_valid,
   output logic [FREE_W-1:0] free_bytes,
   output logic              irq_empty,
   output logic              irq_full,
   output logic              irq_overrun
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < LANES) begin : g_bad_depth
      $error("DEPTH must be a power of two no smaller than the word byte count");
   end
   if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (CW > FREE_W) begin : g_bad_free
      $error("FREE_W too narrow for DEPTH");
   end

   logic [AW-1:0]       wr_ptr, rd_ptr;
   logic [CW-1:0]       count;
   logic [LANES-1:0]    lane_we;
   logic [LANES*8-1:0]  lane_data;

   for (genvar k = 0; k < LANES; k++) begin : g_lane_data
      if (k == 0) begin : g_low
         assign lane_data[7:0] = word_push ? word_data[7:0] : byte_data;
      end else begin : g_high
         assign lane_data[k*8 +: 8] = word_data[k*8 +: 8];
      end
   end

   txq_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .byte_push(byte_push), .word_push(word_push), .pop_req(pop_req),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
      .lane_we(lane_we), .ovr_q(irq_overrun)
   );

   txq_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
      .clk(clk), .wr_ptr(wr_ptr), .lane_we(lane_we), .lane_data(lane_data),
      .rd_ptr(rd_ptr), .rd_data(pop_data)
   );

   assign pop_valid  = (count != '0);
   assign irq_empty  = (count == '0);
   assign irq_full   = (count == CW'(DEPTH));
   assign free_bytes = FREE_W'(DEPTH) - FREE_W'(count);

   assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_empty && irq_full));
   assert_free_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_push && !word_push && !pop_req) |=> $stable(free_bytes));
endmodule

// File: tb/spi_tx_byte_queue_bench.sv
module spi_tx_byte_queue_bench;
   localparam int PERIOD = 10;
   localparam int DEPTH  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_push = 1'b0, word_push = 1'b0, pop_req = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [31:0] word_data = '0;
   logic [7:0]  pop_data;
   logic        pop_valid, irq_empty, irq_full, irq_overrun;
   logic [15:0] free_bytes;

   int checks = 0;
   int errors = 0;

   byte unsigned mq[$];
   bit           m_ovr = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   spi_tx_byte_queue u_spi_tx_byte_queue (
      .clk(clk), .rst_n(rst_n),
      .byte_push(byte_push), .byte_data(byte_data),
      .word_push(word_push), .word_data(word_data),
      .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
      .free_bytes(free_bytes), .irq_empty(irq_empty), .irq_full(irq_full),
      .irq_overrun(irq_overrun)
   );

   // reference model, advanced on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete();
         m_ovr = 1'b0;
      end else begin
         int  fr;
         bit  w_ok, b_ok;
         fr   = DEPTH - mq.size();
         w_ok = word_push && fr >= 4;
         b_ok = byte_push && !word_push && fr >= 1;
         m_ovr = (word_push && !w_ok) || (byte_push && !b_ok);
         if (pop_req && mq.size() > 0) void'(mq.pop_front());
         if (w_ok) begin
            for (int k = 0; k < 4; k++) mq.push_back(word_data[k*8 +: 8]);
         end else if (b_ok) begin
            mq.push_back(byte_data);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string ovr_tag);
      chk("R4 free_bytes", free_bytes, DEPTH - mq.size());
      chk("R5 irq_empty", irq_empty, mq.size() == 0);
      chk("R5 irq_full", irq_full, mq.size() == DEPTH);
      chk("R9 pop_valid", pop_valid, mq.size() > 0);
      if (mq.size() > 0) chk("R9/R2/R3 pop_data", pop_data, mq[0]);
      chk(ovr_tag, irq_overrun, m_ovr);
   endtask

   task automatic step(input bit b, input logic [7:0] bd, input bit w,
                       input logic [31:0] wd, input bit p, input string tag);
      byte_push = b; byte_data = bd; word_push = w; word_data = wd; pop_req = p;
      @(posedge clk);
      @(negedge clk);
      byte_push = 1'b0; word_push = 1'b0; pop_req = 1'b0;
      compare_all(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 free_bytes", free_bytes, DEPTH);
      chk("R1 irq_empty", irq_empty, 1);
      chk("R1 irq_full", irq_full, 0);
      chk("R1 irq_overrun", irq_overrun, 0);
      chk("R1 pop_valid", pop_valid, 0);

      // R2 byte pushes then drain
      for (int i = 0; i < 5; i++) step(1, 8'hA0 + 8'(i), 0, '0, 0, "R2 ovr");
      for (int i = 0; i < 5; i++) step(0, '0, 0, '0, 1, "R9 ovr");

      // R3 word byte order
      step(0, '0, 1, 32'h4433_2211, 0, "R3 ovr");
      chk("R3 first byte", pop_data, 8'h11);
      for (int i = 0; i < 4; i++) step(0, '0, 0, '0, 1, "R3 ovr");

      // fill to full with words
      for (int i = 0; i < 16; i++) step(0, '0, 1, 32'h0302_0100 + 32'(i) * 32'h0404_0404, 0, "R3 ovr");
      chk("R5 full after fill", irq_full, 1);
      step(0, '0, 1, 32'hDEAD_BEEF, 0, "R6 word when full");
      chk("R6 overrun pulse", irq_overrun, 1);
      step(1, 8'h5A, 0, '0, 0, "R7 byte when full");
      chk("R7 overrun pulse", irq_overrun, 1);

      // R10 pop plus byte push on full queue: push refused
      step(1, 8'h77, 0, '0, 1, "R10 ovr");
      chk("R10 refused on pre-pop count", free_bytes, 1);

      // bring free to 3, word refused, byte accepted
      step(0, '0, 0, '0, 1, "R9 ovr");
      step(0, '0, 0, '0, 1, "R9 ovr");
      chk("R6 free three", free_bytes, 3);
      step(0, '0, 1, 32'hCAFE_F00D, 0, "R6 word at three free");
      chk("R6 nothing stored", free_bytes, 3);
      step(1, 8'h3C, 0, '0, 0, "R2 ovr");

      // R8 collisions: without and with room
      step(1, 8'h99, 1, 32'h1234_5678, 0, "R8 collision no room");
      for (int i = 0; i < 6; i++) step(0, '0, 0, '0, 1, "R9 ovr");
      step(1, 8'h99, 1, 32'h8765_4321, 0, "R8 collision with room");
      chk("R8 overrun pulse", irq_overrun, 1);

      // drain, then pop on empty
      while (mq.size() > 0) step(0, '0, 0, '0, 1, "R9 ovr");
      step(0, '0, 0, '0, 1, "R9 pop on empty");
      chk("R9 empty stays", free_bytes, DEPTH);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         step(r < 35, 8'($urandom), (r % 7) == 0, $urandom, $urandom_range(0, 2) != 0,
              "R6/R7/R8/R10 random ovr");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule